// File: doc/BRIEF.md
# Queue Occupancy and Allocation Monitor

This block sits beside a tracker queue of up to `DEPTH` entries. It watches one allocate strobe and one release strobe per cycle. From those strobes it keeps its own count of the entries in the queue. A small state machine classifies that count as empty, partial or full. Four statistics counters run on that classification and on that count: the cycles spent full, the cycles spent non-empty, the accepted allocations, and an occupancy integral that adds the live entry count on every clock.

Software reads the occupancy integral and the allocation total and divides one by the other. The result is the mean number of cycles an entry stays in the queue. To measure a pipeline stage by stage, one instance is placed on each stage, for example allocation to lookup reply and miss to identifier grant. The per-stage means then add up to the end-to-end latency. A synchronous clear zeroes all four counters at once without disturbing the entry count.

The state machine has three states. `Q_EMPTY` means the count is 0, `Q_PART` means it lies between 0 and `DEPTH`, and `Q_FULL` means it equals `DEPTH`. The transitions are the following:
- fill-first: `Q_EMPTY` to `Q_PART`, or to `Q_FULL` when `DEPTH` is 1.
- fill-last: `Q_PART` to `Q_FULL`.
- drain-first: `Q_FULL` to `Q_PART`, or to `Q_EMPTY` when `DEPTH` is 1.
- drain-last: `Q_PART` to `Q_EMPTY`.
- hold: the state stays put on every other cycle.

Top module: `qmon_top`

## Requirements
- R1: After reset `occ_level`, all four counters, `ovf_err` and `udf_err` are zero.
- R2: An allocate alone raises `occ_level` by one at the next edge. A release alone lowers it by one. Both strobes together, or neither, leave it unchanged.
- R3: An allocate without a release while `occ_level` equals `DEPTH` raises `ovf_err` in that same cycle. `occ_level` and `alloc_total` are then unchanged.
- R4: A release without an allocate while `occ_level` is 0 raises `udf_err` in that same cycle, and `occ_level` is unchanged. A release together with an allocate while empty is not an error.
- R5: `full_cycles` grows by one for each clock edge at which `occ_level` equals `DEPTH`.
- R6: `busy_cycles` grows by one for each clock edge at which `occ_level` is nonzero.
- R7: `alloc_total` grows by one for each accepted allocate. This includes an allocate that comes together with a release while full.
- R8: `occ_sum` adds the value `occ_level` held before each clock edge.
- R9: With `clr` high at an edge, all four counters read zero after that edge whatever the strobes are. `occ_level` still follows R2 to R4.
- R10: `occ_level` never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of the four counters |
| alloc | input | 1 | An entry is allocated this cycle |
| dealloc | input | 1 | An entry is released this cycle |
| occ_level | output | LW | Current entry count |
| full_cycles | output | CW | Cycles spent full |
| busy_cycles | output | CW | Cycles spent non-empty |
| alloc_total | output | CW | Accepted allocations |
| occ_sum | output | CW | Occupancy integral |
| ovf_err | output | 1 | Allocate refused while full |
| udf_err | output | 1 | Release refused while empty |

## Verification
A wrong entry count or a stale state shows up at `occ_level` one edge after the stimulus that caused it. It also shows up at once in the error pulses, which follow the state directly. A wrong increment reaches the statistics counters at the next edge, and a wrong count goes on shifting `occ_sum` by a wrong amount on every later cycle. The bench walks every level from empty to full and, at each level, applies all eight combinations of allocate, release and clear. A running arithmetic model predicts each counter after every edge.

// File: rtl/qmon_pkg.sv
package qmon_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_e;
endpackage

// File: rtl/qmon_level.sv
module qmon_level
    import qmon_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          dealloc,
    output logic [LW-1:0] level,
    output logic          is_full,
    output logic          is_busy,
    output logic          ovf_err,
    output logic          udf_err
);
    qstate_e       state, state_nxt;
    logic [LW-1:0] lvl_nxt;
    logic          grow, shrink;

    // Only the relevant strobe alone can fault; a paired allocate and release nets out.
    assign ovf_err = alloc & ~dealloc & (state == Q_FULL);
    assign udf_err = dealloc & ~alloc & (state == Q_EMPTY);
    assign grow    = alloc & ~dealloc & ~ovf_err;
    assign shrink  = dealloc & ~alloc & ~udf_err;

    always_comb begin
        lvl_nxt = level;
        if (grow)
            lvl_nxt = level + LW'(1);
        else if (shrink)
            lvl_nxt = level - LW'(1);
    end

    // Next-state process: fill-first, fill-last, drain-first, drain-last, hold.
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: if (grow)
                state_nxt = (lvl_nxt == LW'(DEPTH)) ? Q_FULL : Q_PART;
            Q_PART: begin
                if (grow && lvl_nxt == LW'(DEPTH))
                    state_nxt = Q_FULL;
                else if (shrink && lvl_nxt == '0)
                    state_nxt = Q_EMPTY;
            end
            Q_FULL: if (shrink)
                state_nxt = (lvl_nxt == '0) ? Q_EMPTY : Q_PART;
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
            level <= '0;
        end else begin
            state <= state_nxt;
            level <= lvl_nxt;
        end
    end

    // Output process.
    always_comb begin
        is_full = 1'b0;
        is_busy = 1'b0;
        unique case (state)
            Q_EMPTY: ;
            Q_PART:  is_busy = 1'b1;
            Q_FULL: begin
                is_busy = 1'b1;
                is_full = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R2
    lvl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && dealloc) |=> (level == $past(level)));
    // R3
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> (level == LW'(DEPTH)));
    // R4
    udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        udf_err |=> (level == '0));
endmodule

// File: rtl/qmon_acc.sv
module qmon_acc #(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (clr)
            value <= '0;
        else
            value <= value + W'(inc);
    end

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));
endmodule

// File: rtl/qmon_top.sv
module qmon_top #(
    parameter int DEPTH = 4,
    parameter int CW    = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          alloc,
    input  logic          dealloc,
    output logic [LW-1:0] occ_level,
    output logic [CW-1:0] full_cycles,
    output logic [CW-1:0] busy_cycles,
    output logic [CW-1:0] alloc_total,
    output logic [CW-1:0] occ_sum,
    output logic          ovf_err,
    output logic          udf_err
);
    logic is_full, is_busy, take;

    qmon_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst_n(rst_n), .alloc(alloc), .dealloc(dealloc),
        .level(occ_level), .is_full(is_full), .is_busy(is_busy),
        .ovf_err(ovf_err), .udf_err(udf_err)
    );

    assign take = alloc & ~ovf_err;

    qmon_acc #(.W(CW), .IW(1)) u_full (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(is_full), .value(full_cycles));
    qmon_acc #(.W(CW), .IW(1)) u_busy (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(is_busy), .value(busy_cycles));
    qmon_acc #(.W(CW), .IW(1)) u_alloc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(take), .value(alloc_total));
    qmon_acc #(.W(CW), .IW(LW)) u_occ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(occ_level), .value(occ_sum));

    // R5
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && occ_level == LW'(DEPTH)) |=> (full_cycles == $past(full_cycles) + CW'(1)));
    // R6
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && occ_level == '0) |=> $stable(busy_cycles));
    // R7
    ovf_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ovf_err) |=> $stable(alloc_total));
    // R8
    occ_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (occ_sum == $past(occ_sum) + CW'($past(occ_level))));
endmodule

// File: tb/tb_qmon_top.sv
module tb_qmon_top;
    localparam int D  = 4;
    localparam int CW = 32;
    localparam int LW = $clog2(D + 1);

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, alloc = 1'b0, dealloc = 1'b0;
    logic [LW-1:0] occ_level;
    logic [CW-1:0] full_cycles, busy_cycles, alloc_total, occ_sum;
    logic ovf_err, udf_err;

    int checks = 0, errors = 0;
    int m = 0;
    longint e_full = 0, e_busy = 0, e_alloc = 0, e_occ = 0;

    qmon_top #(.DEPTH(D), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .alloc(alloc), .dealloc(dealloc),
        .occ_level(occ_level), .full_cycles(full_cycles), .busy_cycles(busy_cycles),
        .alloc_total(alloc_total), .occ_sum(occ_sum), .ovf_err(ovf_err), .udf_err(udf_err));

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit a, input bit d, input bit c);
        bit ovf, udf;
        @(negedge clk);
        alloc = a; dealloc = d; clr = c;
        ovf = a && !d && (m == D);
        udf = d && !a && (m == 0);
        #1;
        chk(ovf_err == ovf, "R3 ovf_err", ovf_err, ovf);
        chk(udf_err == udf, "R4 udf_err", udf_err, udf);
        @(posedge clk);
        if (c) begin
            e_full = 0; e_busy = 0; e_alloc = 0; e_occ = 0;
        end else begin
            e_full += (m == D);
            e_busy += (m != 0);
            e_occ += m;
            e_alloc += (a && !ovf);
        end
        if (a && !d && !ovf) m++;
        else if (d && !a && !udf) m--;
        #2;
        chk(occ_level == LW'(m), "R2 level", occ_level, m);
        chk(occ_level <= LW'(D), "R10 bound", occ_level, D);
        chk(full_cycles == CW'(e_full), c ? "R9 full clr" : "R5 full", full_cycles, e_full);
        chk(busy_cycles == CW'(e_busy), c ? "R9 busy clr" : "R6 busy", busy_cycles, e_busy);
        chk(alloc_total == CW'(e_alloc), c ? "R9 alloc clr" : "R7 alloc", alloc_total, e_alloc);
        chk(occ_sum == CW'(e_occ), c ? "R9 occ clr" : "R8 occ", occ_sum, e_occ);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #25;
        // R1 reset state
        chk(occ_level == '0, "R1 level", occ_level, 0);
        chk(full_cycles == '0 && busy_cycles == '0, "R1 cyc", full_cycles + busy_cycles, 0);
        chk(alloc_total == '0 && occ_sum == '0, "R1 alloc/occ", alloc_total + occ_sum, 0);
        chk(!ovf_err && !udf_err, "R1 err", ovf_err + udf_err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 release while empty, R3 overfill
        step(0, 1, 0);
        for (int i = 0; i < D + 2; i++) step(1, 0, 0);
        step(1, 1, 0);
        for (int i = 0; i < D + 1; i++) step(0, 1, 0);
        // Sweep every level against all strobe and clear combinations
        for (int tgt = 0; tgt <= D; tgt++) begin
            for (int combo = 0; combo < 8; combo++) begin
                while (m < tgt) step(1, 0, 0);
                while (m > tgt) step(0, 1, 0);
                step(combo[0], combo[1], combo[2]);
                step(0, 0, 0);
            end
        end
        // Long full residency then drain
        for (int i = 0; i < D; i++) step(1, 0, 0);
        for (int i = 0; i < 20; i++) step(0, 0, 0);
        for (int i = 0; i < D; i++) step(0, 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule